// File: doc/BRIEF.md
# Mode Register Set Sequencer

This block sits on the controller side of a DDR3-style memory interface and owns the moment when a mode register is rewritten. A requester presents a register index and a value. The sequencer then waits until it is safe to issue the write. That means every bank is precharged, no read or write data burst is running, and the precharge interval has expired since the last precharge command. Once all of that holds, it places a single MRS command on the command bus. From then on it keeps the bus quiet until the mode-update interval has passed.

While the request is outstanding and during the quiet window, a block output tells the rest of the controller to stall its own commands. The sequencer also overrides two pins. Termination (ODT) is forced low from the MRS cycle until the mode-update interval ends. CKE is forced high from the wait for preconditions until the power-down-entry interval after the MRS has passed, so no power-down request gets through early. All intervals are parameters counted in clock cycles. Power-down entry policy, refresh scheduling and the physical layer are handled elsewhere.

Top module: `mrs_sequencer`

## Requirements
- R1: After reset the command output is DES (code 2'b00), busy, cmd_block and done are low, and odt_out and cke_out follow odt_req and cke_req.
- R2: No MRS is issued while any bit of bank_idle is low; once all banks are idle, with the other preconditions true, the MRS (code 2'b10) appears in the next cycle.
- R3: A request that arrives while burst_active is high is held pending, not dropped, and the MRS appears in the cycle after the first cycle with burst_active low.
- R4: After a precharge pulse on pre_issued in cycle p, the precharge precondition is first met in cycle p+T_RP, so the MRS appears no earlier than cycle p+T_RP+1.
- R5: The MRS is driven for exactly one cycle, with mr_sel_out and mr_val_out equal to the index and value captured with the request. In every other cycle the command is DES and both fields read zero.
- R6: cmd_block is high from the cycle after a request is accepted until T_MOD cycles after the MRS cycle, then low.
- R7: done pulses high for one cycle, exactly T_MOD cycles after the MRS cycle.
- R8: odt_out is low in the MRS cycle and in the following T_MOD-1 cycles whatever odt_req is, and follows odt_req again from the T_MOD-th cycle after the MRS.
- R9: cke_out is high while waiting for preconditions, in the MRS cycle and in the following T_MRSPDEN-1 cycles whatever cke_req is, and follows cke_req afterwards.
- R10: A request made while busy is high is ignored: it neither changes the register value written nor causes a second MRS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request to write a mode register (taken only when not busy) |
| req_sel | input | MR_SEL_W | Index of the mode register to write |
| req_value | input | MR_VAL_W | Value to write |
| bank_idle | input | NUM_BANKS | One bit per bank, high when that bank is precharged |
| burst_active | input | 1 | High while a read or write data burst is in progress |
| pre_issued | input | 1 | One-cycle pulse when a precharge command goes out |
| odt_req | input | 1 | Termination level requested by the rest of the controller |
| cke_req | input | 1 | Clock-enable level requested (low asks for power-down) |
| busy | output | 1 | A request is being processed |
| cmd_block | output | 1 | Other command sources must stall |
| cmd_out | output | 2 | Command code: 2'b00 DES, 2'b01 NOP, 2'b10 MRS |
| mr_sel_out | output | MR_SEL_W | Register index, valid with MRS |
| mr_val_out | output | MR_VAL_W | Register value, valid with MRS |
| odt_out | output | 1 | Termination pin drive |
| cke_out | output | 1 | Clock-enable pin drive |
| done | output | 1 | One-cycle pulse when the mode-update interval ends |

## Verification
The bench builds the sequencer with eight banks, T_RP of 5, T_MOD of 12 and T_MRSPDEN of 16. Because T_MRSPDEN is longer than T_MOD, the release of ODT and the release of CKE fall on different cycles, and each window edge can be checked on its own. A T_RP of 5 leaves room to request an MRS in the middle of the precharge interval and see exactly where it is first allowed. Blocking one bank and holding a burst active show that a request is kept pending, not dropped.

// File: rtl/mrs_seq_pkg.sv
package mrs_seq_pkg;

  typedef enum logic [1:0] {
    CMD_DES = 2'b00,
    CMD_NOP = 2'b01,
    CMD_MRS = 2'b10
  } mrs_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE         = 3'd0,
    ST_WAIT_PRECOND = 3'd1,
    ST_ISSUE_MRS    = 3'd2,
    ST_WAIT_TMOD    = 3'd3,
    ST_DONE         = 3'd4
  } mrs_state_e;

endpackage

// File: rtl/mrs_reset_sync.sv
module mrs_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage1     <= 1'b1;
      rst_sync_n <= stage1;
    end
  end
endmodule

// File: rtl/mrs_cycle_timer.sv
module mrs_cycle_timer #(
  parameter int unsigned LOAD_VAL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic running,
  output logic final_tick
);
  localparam int unsigned W = (LOAD_VAL < 1) ? 1 : $clog2(LOAD_VAL + 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = W'(LOAD_VAL);
    else      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign running    = (cnt_q != '0);
  assign final_tick = (cnt_q == W'(1));
endmodule

// File: rtl/mrs_precond_check.sv
module mrs_precond_check #(
  parameter int unsigned NUM_BANKS = 8
) (
  input  logic [NUM_BANKS-1:0] bank_idle,
  input  logic                 burst_active,
  input  logic                 trp_running,
  input  logic                 pre_issued,
  output logic                 ok
);
  logic all_idle;
  logic trp_met;

  assign all_idle = &bank_idle;
  assign trp_met  = !trp_running && !pre_issued;
  assign ok       = all_idle && !burst_active && trp_met;
endmodule

// File: rtl/mrs_sequencer.sv
module mrs_sequencer
  import mrs_seq_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned MR_SEL_W  = 2,
  parameter int unsigned MR_VAL_W  = 14,
  parameter int unsigned T_RP      = 5,
  parameter int unsigned T_MOD     = 12,
  parameter int unsigned T_MRSPDEN = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [MR_SEL_W-1:0]  req_sel,
  input  logic [MR_VAL_W-1:0]  req_value,
  input  logic [NUM_BANKS-1:0] bank_idle,
  input  logic                 burst_active,
  input  logic                 pre_issued,
  input  logic                 odt_req,
  input  logic                 cke_req,
  output logic                 busy,
  output logic                 cmd_block,
  output logic [1:0]           cmd_out,
  output logic [MR_SEL_W-1:0]  mr_sel_out,
  output logic [MR_VAL_W-1:0]  mr_val_out,
  output logic                 odt_out,
  output logic                 cke_out,
  output logic                 done
);
  localparam int unsigned RP_LOAD   = (T_RP > 0) ? T_RP - 1 : 0;
  localparam int unsigned MOD_LOAD  = (T_MOD > 1) ? T_MOD - 1 : 1;
  localparam int unsigned PDEN_LOAD = (T_MRSPDEN > 0) ? T_MRSPDEN - 1 : 0;

  logic rst_sync_n;

  mrs_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mrs_state_e state_q, state_d;

  logic issue_now;
  logic trp_running, trp_last;
  logic tmod_running, tmod_last;
  logic pden_running, pden_last;
  logic precond_ok;
  logic capture_en;

  logic [MR_SEL_W-1:0] sel_q;
  logic [MR_VAL_W-1:0] val_q;

  assign issue_now  = (state_q == ST_ISSUE_MRS);
  assign capture_en = (state_q == ST_IDLE) && req_valid;

  mrs_cycle_timer #(.LOAD_VAL(RP_LOAD)) u_trp (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (pre_issued),
    .running    (trp_running),
    .final_tick (trp_last)
  );

  mrs_cycle_timer #(.LOAD_VAL(MOD_LOAD)) u_tmod (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (issue_now),
    .running    (tmod_running),
    .final_tick (tmod_last)
  );

  mrs_cycle_timer #(.LOAD_VAL(PDEN_LOAD)) u_pden (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load       (issue_now),
    .running    (pden_running),
    .final_tick (pden_last)
  );

  mrs_precond_check #(.NUM_BANKS(NUM_BANKS)) u_pre (
    .bank_idle    (bank_idle),
    .burst_active (burst_active),
    .trp_running  (trp_running),
    .pre_issued   (pre_issued),
    .ok           (precond_ok)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:         if (req_valid)  state_d = ST_WAIT_PRECOND;
      ST_WAIT_PRECOND: if (precond_ok) state_d = ST_ISSUE_MRS;
      ST_ISSUE_MRS:                    state_d = ST_WAIT_TMOD;
      ST_WAIT_TMOD:    if (tmod_last)  state_d = ST_DONE;
      ST_DONE:                         state_d = ST_IDLE;
      default:                         state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  // request capture, enabled only when idle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q <= '0;
      val_q <= '0;
    end else if (capture_en) begin
      sel_q <= req_sel;
      val_q <= req_value;
    end
  end

  // outputs
  logic waiting;
  logic odt_hold;
  logic cke_hold;

  assign waiting  = (state_q == ST_WAIT_PRECOND);
  assign odt_hold = issue_now || (state_q == ST_WAIT_TMOD);
  assign cke_hold = waiting || issue_now || pden_running;

  assign busy       = (state_q != ST_IDLE);
  assign cmd_block  = waiting || issue_now || (state_q == ST_WAIT_TMOD);
  assign cmd_out    = issue_now ? CMD_MRS : CMD_DES;
  assign mr_sel_out = issue_now ? sel_q : '0;
  assign mr_val_out = issue_now ? val_q : '0;
  assign odt_out    = odt_req && !odt_hold;
  assign cke_out    = cke_req || cke_hold;
  assign done       = (state_q == ST_DONE);

  logic unused_ok;
  assign unused_ok = trp_last ^ pden_last ^ tmod_running;

endmodule

// File: rtl/mrs_sequencer_checker.sv
module mrs_sequencer_checker #(
  parameter int unsigned NUM_BANKS = 8,
  parameter int unsigned T_MOD     = 12,
  parameter int unsigned T_MRSPDEN = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_BANKS-1:0] bank_idle,
  input logic                 burst_active,
  input logic [1:0]           cmd_out,
  input logic                 cmd_block,
  input logic                 odt_out,
  input logic                 cke_out,
  input logic                 done
);
  localparam logic [1:0] MRS = 2'b10;

  // cycles since the last MRS; saturates, all ones means none yet
  logic [15:0] since_mrs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     since_mrs <= 16'hFFFF;
    else if (cmd_out == MRS)        since_mrs <= 16'd1;
    else if (since_mrs != 16'hFFFF) since_mrs <= since_mrs + 16'd1;
  end

  a_r2_banks_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == MRS) |-> $past(&bank_idle));

  a_r3_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == MRS) |-> $past(!burst_active));

  a_r5_single_mrs: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_out == MRS) |=> (cmd_out != MRS));

  a_r6_block_window: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_out == MRS) || (since_mrs < 16'(T_MOD))) |-> cmd_block);

  a_r7_done_timing: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (since_mrs == 16'(T_MOD)));

  a_r8_odt_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_out == MRS) || (since_mrs < 16'(T_MOD))) |-> !odt_out);

  a_r9_cke_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_out == MRS) || (since_mrs < 16'(T_MRSPDEN))) |-> cke_out);

endmodule

bind mrs_sequencer mrs_sequencer_checker #(
  .NUM_BANKS (NUM_BANKS),
  .T_MOD     (T_MOD),
  .T_MRSPDEN (T_MRSPDEN)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bank_idle    (bank_idle),
  .burst_active (burst_active),
  .cmd_out      (cmd_out),
  .cmd_block    (cmd_block),
  .odt_out      (odt_out),
  .cke_out      (cke_out),
  .done         (done)
);

// File: tb/mrs_sequencer_test.sv
module mrs_sequencer_test;
  localparam int NB   = 8;
  localparam int SW   = 2;
  localparam int VW   = 14;
  localparam int TRP  = 5;
  localparam int TMOD = 12;
  localparam int TPD  = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [SW-1:0] req_sel;
  logic [VW-1:0] req_value;
  logic [NB-1:0] bank_idle;
  logic          burst_active, pre_issued, odt_req, cke_req;
  logic          busy, cmd_block, odt_out, cke_out, done;
  logic [1:0]    cmd_out;
  logic [SW-1:0] mr_sel_out;
  logic [VW-1:0] mr_val_out;

  int n_checks = 0;
  int n_err    = 0;
  int cyc      = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mrs_sequencer #(
    .NUM_BANKS(NB), .MR_SEL_W(SW), .MR_VAL_W(VW),
    .T_RP(TRP), .T_MOD(TMOD), .T_MRSPDEN(TPD)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_value(req_value), .bank_idle(bank_idle), .burst_active(burst_active),
    .pre_issued(pre_issued), .odt_req(odt_req), .cke_req(cke_req),
    .busy(busy), .cmd_block(cmd_block), .cmd_out(cmd_out),
    .mr_sel_out(mr_sel_out), .mr_val_out(mr_val_out),
    .odt_out(odt_out), .cke_out(cke_out), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done(input string req);
    int k;
    for (k = 0; k < 200 && !done; k++) tick();
    check_eq({req, " done seen"}, int'(done), 1);
    tick();
  endtask

  task automatic send_req(input logic [SW-1:0] s, input logic [VW-1:0] v);
    req_valid = 1'b1; req_sel = s; req_value = v;
    tick();
    req_valid = 1'b0; req_sel = '0; req_value = '0;
  endtask

  task automatic t_reset();
    odt_req = 1'b1; cke_req = 1'b0;
    tick();
    check_eq("R1 cmd", int'(cmd_out), 0);
    check_eq("R1 busy", int'(busy), 0);
    check_eq("R1 block", int'(cmd_block), 0);
    check_eq("R1 done", int'(done), 0);
    check_eq("R1 odt follows", int'(odt_out), 1);
    check_eq("R1 cke follows", int'(cke_out), 0);
    cke_req = 1'b1;
  endtask

  task automatic t_basic();
    odt_req = 1'b1; cke_req = 1'b0;
    send_req(2'd2, 14'h1A5);
    check_eq("R6 block while waiting", int'(cmd_block), 1);
    check_eq("R9 cke held while waiting", int'(cke_out), 1);
    check_eq("R5 DES before MRS", int'(cmd_out), 0);
    tick();
    check_eq("R5 MRS cmd", int'(cmd_out), 2);
    check_eq("R5 MRS sel", int'(mr_sel_out), 2);
    check_eq("R5 MRS val", int'(mr_val_out), 'h1A5);
    check_eq("R8 odt low at MRS", int'(odt_out), 0);
    check_eq("R9 cke high at MRS", int'(cke_out), 1);
    for (int k = 1; k <= TPD + 1; k++) begin
      tick();
      check_eq("R5 DES after MRS", int'(cmd_out), 0);
      check_eq("R5 val zero after MRS", int'(mr_val_out), 0);
      check_eq("R6 block window", int'(cmd_block), (k < TMOD) ? 1 : 0);
      check_eq("R7 done pulse", int'(done), (k == TMOD) ? 1 : 0);
      check_eq("R8 odt window", int'(odt_out), (k < TMOD) ? 0 : 1);
      check_eq("R9 cke window", int'(cke_out), (k < TPD) ? 1 : 0);
    end
    check_eq("R6 idle again", int'(busy), 0);
    odt_req = 1'b0; cke_req = 1'b1;
  endtask

  task automatic t_bank_busy();
    bank_idle = 8'hFB;
    send_req(2'd0, 14'h0321);
    for (int k = 0; k < 6; k++) begin
      check_eq("R2 no MRS with busy bank", int'(cmd_out == 2'b10), 0);
      tick();
    end
    bank_idle = '1;
    tick();
    check_eq("R2 MRS after banks idle", int'(cmd_out), 2);
    check_eq("R2 value", int'(mr_val_out), 'h0321);
    wait_done("R2");
  endtask

  task automatic t_burst();
    burst_active = 1'b1;
    send_req(2'd1, 14'h2BCD);
    for (int k = 0; k < 5; k++) begin
      check_eq("R3 no MRS during burst", int'(cmd_out == 2'b10), 0);
      check_eq("R3 request pending", int'(busy), 1);
      tick();
    end
    burst_active = 1'b0;
    tick();
    check_eq("R3 MRS after burst", int'(cmd_out), 2);
    check_eq("R3 sel kept", int'(mr_sel_out), 1);
    check_eq("R3 value kept", int'(mr_val_out), 'h2BCD);
    wait_done("R3");
  endtask

  task automatic t_trp();
    // precharge pulse in cycle p, request in p+1
    pre_issued = 1'b1;
    tick();
    pre_issued = 1'b0;
    send_req(2'd3, 14'h0777);
    // now in cycle p+2
    for (int k = 2; k < TRP; k++) begin
      check_eq("R4 no MRS inside tRP", int'(cmd_out == 2'b10), 0);
      tick();
    end
    check_eq("R4 no MRS at p+T_RP", int'(cmd_out == 2'b10), 0);
    tick();
    check_eq("R4 MRS at p+T_RP+1", int'(cmd_out), 2);
    wait_done("R4");
  endtask

  task automatic t_ignore();
    int mrs_seen;
    send_req(2'd1, 14'h0AAA);
    send_req(2'd2, 14'h1555);
    check_eq("R10 first value written", int'(mr_val_out), 'h0AAA);
    check_eq("R10 first sel written", int'(mr_sel_out), 1);
    wait_done("R10");
    mrs_seen = 0;
    for (int k = 0; k < 20; k++) begin
      if (cmd_out == 2'b10) mrs_seen++;
      tick();
    end
    check_eq("R10 no second MRS", mrs_seen, 0);
    check_eq("R10 not busy", int'(busy), 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_sel = '0; req_value = '0;
    bank_idle = '1; burst_active = 1'b0; pre_issued = 1'b0;
    odt_req = 1'b0; cke_req = 1'b1;
    repeat (4) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_basic();
    t_bank_busy();
    t_burst();
    t_trp();
    t_ignore();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule